// File: doc/BRIEF.md
# Program-Memory Check-Bit Controller (Parity or Breakpoint Tags)

This block sits between a processor's memory bus and a program memory in which every word carries one extra bit beside its data bits. The meaning of that bit is chosen by an 8-bit control register. In protection mode the bit holds the even parity of the data. It is produced on every write and, when error reporting is switched on, compared on every fetch or data read. In debug mode the bit is a per-address stop tag. An access to a tagged word raises an interrupt pulse, so a program may have as many breakpoints as it has words, and tagging every word gives single-stepping.

Accesses arrive as a valid/ready request stream and leave as a valid/ready response stream. Only one access is in flight at a time: `req_ready_o` is low while a response is waiting. A response appears in the cycle after the request is taken and is held, with stable data, until `rsp_ready_i` is high at a clock edge. Each access reads the addressed word, and a write stores the new word in the same edge, read-first. The response therefore carries the word as it stood before the access. The tag on that word is what decides a trace event, even for a write.

To switch modes, software writes the control register and then reads and rewrites every word. To enter debug it clears the register first. To leave debug it enables parity generation, rewrites memory, and only then turns on error reporting. Breakpoints are placed by forcing the extra bit during writes to the chosen addresses.

Top module: `tagmem_top`

## Requirements
- R1: After reset the control register and the sticky interrupt flag are 0, `rsp_valid_o`, `irq_o` and `err_o` are low, and `req_ready_o` is high.
- R2: A request is taken at a rising edge where `req_valid_i` and `req_ready_o` are both high. `rsp_valid_o` rises in the next cycle and stays high, with `rsp_rdata_o` and `rsp_tag_o` stable, until an edge with `rsp_ready_i` high. `req_ready_o` is low while `rsp_valid_o` is high.
- R3: `rsp_rdata_o` and `rsp_tag_o` give the data and extra bit of the addressed word as stored before the access. `req_kind_i` codes are 0 fetch, 1 data read, 2 data write and 3 data read. Only code 2 writes `req_wdata_i`.
- R4: With control bit 0 (force) set, a write stores control bit 1 (force value) as the extra bit, whatever the data.
- R5: With bit 0 clear and control bit 3 (parity generate) set, a write stores the XOR of all data bits as the extra bit, so each word has even parity.
- R6: With bits 0 and 3 both clear, a write stores 0 as the extra bit.
- R7: `irq_o` pulses high for exactly the first response cycle when control bit 2 (trace) is set, the word's prior extra bit is 1, and the kind's mask bit is set. The mask bits are bit 5 for fetch, bit 6 for data read and bit 7 for data write.
- R8: `irq_sticky_o` goes high in the cycle after an `irq_o` pulse. It is cleared by a control-register write (`cfg_we_i`), and a pulse in the same cycle as that write takes precedence.
- R9: `err_o` pulses high for exactly the first response cycle of a fetch or data read when control bit 4 (error report) is set and the stored extra bit differs from the data's XOR. It never pulses on a write or while bit 4 is clear.
- R10: When every word of a range is tagged, each fetch in that range with trace and the fetch mask set raises one interrupt, which allows single-stepping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Access request valid |
| req_ready_o | output | 1 | Request can be taken |
| req_kind_i | input | 2 | 0 fetch, 1 read, 2 write, 3 read |
| req_addr_i | input | AW | Word address |
| req_wdata_i | input | DW | Write data |
| rsp_valid_o | output | 1 | Response valid |
| rsp_ready_i | input | 1 | Response consumed |
| rsp_rdata_o | output | DW | Prior data of the addressed word |
| rsp_tag_o | output | 1 | Prior extra bit of the addressed word |
| cfg_we_i | input | 1 | Control register write strobe |
| cfg_wdata_i | input | 8 | Control register value |
| irq_o | output | 1 | Trace compare interrupt pulse |
| irq_sticky_o | output | 1 | Held interrupt flag |
| err_o | output | 1 | Parity error pulse |

## Verification
Memory is first filled in debug mode with a cleared register, so every tag is 0. A few addresses are then tagged through forced writes, and fetches, reads and writes are issued with one mask bit set at a time and then with all three. This separates a correct kind decode from a swapped or ignored mask, and it shows that a write is judged on the old tag and leaves behind the tag its own mode produces. The memory is then rewritten in parity mode with data of both parities. A word with deliberately wrong parity is then read with error reporting on, read with it off, and written, which shows when the error pulse must and must not appear. Responses are also stalled for several cycles to show that the output holds and that no request is taken meanwhile. A final tagged block is fetched in full to count one interrupt per instruction.

// File: rtl/tagmem_pkg.sv
package tagmem_pkg;

  localparam int CFG_W = 8;

  localparam logic [1:0] KIND_FETCH  = 2'd0;
  localparam logic [1:0] KIND_READ   = 2'd1;
  localparam logic [1:0] KIND_WRITE  = 2'd2;
  localparam logic [1:0] KIND_READ_B = 2'd3;

  // bit 0 is force, bit 7 is write-trace mask
  typedef struct packed {
    logic trc_write;
    logic trc_read;
    logic trc_fetch;
    logic err_en;
    logic par_en;
    logic trace_en;
    logic force_val;
    logic force_en;
  } ctrl_t;

endpackage

// File: rtl/tagmem_ctrl_reg.sv
module tagmem_ctrl_reg
  import tagmem_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CFG_W-1:0] wdata_i,
  input  logic             evt_i,
  output ctrl_t            ctrl_o,
  output logic             sticky_o
);

  ctrl_t ctrl_q;
  logic  sticky_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
    end else if (we_i) begin
      ctrl_q <= ctrl_t'(wdata_i);
    end
  end

  // a new event outranks the clear carried by a register write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sticky_q <= 1'b0;
    end else if (evt_i) begin
      sticky_q <= 1'b1;
    end else if (we_i) begin
      sticky_q <= 1'b0;
    end
  end

  assign ctrl_o   = ctrl_q;
  assign sticky_o = sticky_q;

endmodule

// File: rtl/tagmem_array.sv
module tagmem_array #(
  parameter int AW = 6,
  parameter int W  = 9
) (
  input  logic          clk_i,
  input  logic          en_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [W-1:0]  wdata_i,
  output logic [W-1:0]  rdata_o
);

  localparam int DEPTH = 1 << AW;

  logic [W-1:0] mem_q [DEPTH];
  logic [W-1:0] rd_q;

  // read-first: the old word is returned while the new one lands
  always_ff @(posedge clk_i) begin
    if (en_i) begin
      rd_q <= mem_q[addr_i];
      if (we_i) begin
        mem_q[addr_i] <= wdata_i;
      end
    end
  end

  assign rdata_o = rd_q;

endmodule

// File: rtl/tagmem_tag_policy.sv
module tagmem_tag_policy #(
  parameter int DW         = 8,
  parameter bit ODD_PARITY = 1'b0
) (
  input  logic          force_en_i,
  input  logic          force_val_i,
  input  logic          par_en_i,
  input  logic [DW-1:0] wdata_i,
  output logic          wtag_o,
  input  logic [DW-1:0] rdata_i,
  input  logic          rtag_i,
  output logic          mismatch_o
);

  logic par_w;
  logic par_r;

  generate
    if (ODD_PARITY) begin : g_odd
      assign par_w = ~(^wdata_i);
      assign par_r = ~(^rdata_i);
    end else begin : g_even
      assign par_w = ^wdata_i;
      assign par_r = ^rdata_i;
    end
  endgenerate

  always_comb begin
    if (force_en_i) begin
      wtag_o = force_val_i;
    end else if (par_en_i) begin
      wtag_o = par_w;
    end else begin
      wtag_o = 1'b0;
    end
  end

  assign mismatch_o = par_r ^ rtag_i;

endmodule

// File: rtl/tagmem_top.sv
module tagmem_top
  import tagmem_pkg::*;
#(
  parameter int AW         = 6,
  parameter int DW         = 8,
  parameter bit ODD_PARITY = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic [1:0]       req_kind_i,
  input  logic [AW-1:0]    req_addr_i,
  input  logic [DW-1:0]    req_wdata_i,
  output logic             rsp_valid_o,
  input  logic             rsp_ready_i,
  output logic [DW-1:0]    rsp_rdata_o,
  output logic             rsp_tag_o,
  input  logic             cfg_we_i,
  input  logic [CFG_W-1:0] cfg_wdata_i,
  output logic             irq_o,
  output logic             irq_sticky_o,
  output logic             err_o
);

  localparam int WW = DW + 1;

  ctrl_t          ctrl;
  logic           take;
  logic           pend_q;
  logic           fresh_q;
  logic [1:0]     kind_q;
  logic           wtag;
  logic           mismatch;
  logic [WW-1:0]  rd_word;
  logic [DW-1:0]  rd_data;
  logic           rd_tag;
  logic           mask_hit;
  logic           irq_evt;

  assign take = req_valid_i & ~pend_q;

  tagmem_ctrl_reg u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (cfg_we_i),
    .wdata_i  (cfg_wdata_i),
    .evt_i    (irq_evt),
    .ctrl_o   (ctrl),
    .sticky_o (irq_sticky_o)
  );

  tagmem_tag_policy #(
    .DW         (DW),
    .ODD_PARITY (ODD_PARITY)
  ) u_policy (
    .force_en_i  (ctrl.force_en),
    .force_val_i (ctrl.force_val),
    .par_en_i    (ctrl.par_en),
    .wdata_i     (req_wdata_i),
    .wtag_o      (wtag),
    .rdata_i     (rd_data),
    .rtag_i      (rd_tag),
    .mismatch_o  (mismatch)
  );

  tagmem_array #(
    .AW (AW),
    .W  (WW)
  ) u_array (
    .clk_i   (clk_i),
    .en_i    (take),
    .we_i    (req_kind_i == KIND_WRITE),
    .addr_i  (req_addr_i),
    .wdata_i ({wtag, req_wdata_i}),
    .rdata_o (rd_word)
  );

  assign rd_data = rd_word[DW-1:0];
  assign rd_tag  = rd_word[DW];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q  <= 1'b0;
      fresh_q <= 1'b0;
      kind_q  <= KIND_FETCH;
    end else begin
      fresh_q <= take;
      if (take) begin
        pend_q <= 1'b1;
        kind_q <= req_kind_i;
      end else if (rsp_ready_i) begin
        pend_q <= 1'b0;
      end
    end
  end

  always_comb begin
    unique case (kind_q)
      KIND_FETCH:  mask_hit = ctrl.trc_fetch;
      KIND_WRITE:  mask_hit = ctrl.trc_write;
      KIND_READ,
      KIND_READ_B: mask_hit = ctrl.trc_read;
      default:     mask_hit = 1'b0;
    endcase
  end

  assign irq_evt = fresh_q & ctrl.trace_en & rd_tag & mask_hit;

  assign req_ready_o = ~pend_q;
  assign rsp_valid_o = pend_q;
  assign rsp_rdata_o = rd_data;
  assign rsp_tag_o   = rd_tag;
  assign irq_o       = irq_evt;
  assign err_o       = fresh_q & ctrl.err_en & (kind_q != KIND_WRITE) & mismatch;

endmodule

// File: rtl/tagmem_top_chk.sv
module tagmem_top_chk #(
  parameter int DW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_ready_o,
  input logic          rsp_valid_o,
  input logic          rsp_ready_i,
  input logic [DW-1:0] rsp_rdata_o,
  input logic          rsp_tag_o,
  input logic          cfg_we_i,
  input logic          irq_o,
  input logic          irq_sticky_o,
  input logic          err_o,
  input logic [1:0]    kind_q
);

  assert_rsp_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !rsp_ready_i |=> rsp_valid_o && $stable(rsp_rdata_o) && $stable(rsp_tag_o));

  assert_busy_block_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> !req_ready_o);

  assert_irq_tagged_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> rsp_valid_o && rsp_tag_o);

  assert_irq_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);

  assert_sticky_set_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> irq_sticky_o);

  assert_sticky_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i && !irq_o |=> !irq_sticky_o);

  assert_err_not_write_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> rsp_valid_o && (kind_q != 2'd2));

  assert_err_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> !err_o);

endmodule

bind tagmem_top tagmem_top_chk #(.DW(DW)) chk_i (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_ready_o  (req_ready_o),
  .rsp_valid_o  (rsp_valid_o),
  .rsp_ready_i  (rsp_ready_i),
  .rsp_rdata_o  (rsp_rdata_o),
  .rsp_tag_o    (rsp_tag_o),
  .cfg_we_i     (cfg_we_i),
  .irq_o        (irq_o),
  .irq_sticky_o (irq_sticky_o),
  .err_o        (err_o),
  .kind_q       (kind_q)
);

// File: tb/tagmem_top_tb_top.sv
`timescale 1ns/1ps
module tagmem_top_tb_top;

  localparam int AW = 6;
  localparam int DW = 8;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [1:0] req_kind = 2'd0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic rsp_ready = 1'b0;
  logic cfg_we = 1'b0;
  logic [7:0] cfg_wdata = '0;
  logic req_ready, rsp_valid, rsp_tag, irq, irq_sticky, err;
  logic [DW-1:0] rsp_rdata;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit cmp_on = 1'b0;

  always #2 clk = ~clk;

  tagmem_top #(.AW(AW), .DW(DW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_kind_i(req_kind), .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_ready_i(rsp_ready),
    .rsp_rdata_o(rsp_rdata), .rsp_tag_o(rsp_tag),
    .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wdata),
    .irq_o(irq), .irq_sticky_o(irq_sticky), .err_o(err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int m_dat[DEPTH];
  int m_tag[DEPTH];
  int m_cfg, m_rdata, m_rtag, m_kind;
  bit m_pend, m_fresh, m_sticky;

  function automatic int par8(input int v);
    return ^(v[7:0]);
  endfunction

  function automatic bit exp_irq();
    bit m;
    if (m_kind == 0) m = m_cfg[5];
    else if (m_kind == 2) m = m_cfg[7];
    else m = m_cfg[6];
    return m_fresh && m_cfg[2] && (m_rtag == 1) && m;
  endfunction

  function automatic bit exp_err();
    return m_fresh && m_cfg[4] && (m_kind != 2) && (par8(m_rdata) != m_rtag);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cfg <= 0; m_pend <= 0; m_fresh <= 0; m_sticky <= 0; m_kind <= 0;
    end else begin
      bit evt;
      evt = exp_irq();
      m_fresh <= 0;
      if (!m_pend && req_valid) begin
        int a, nt;
        a = int'(req_addr);
        m_rdata <= m_dat[a];
        m_rtag <= m_tag[a];
        m_pend <= 1;
        m_fresh <= 1;
        m_kind <= int'(req_kind);
        if (req_kind == 2'd2) begin
          if (m_cfg[0]) nt = m_cfg[1];
          else if (m_cfg[3]) nt = par8(int'(req_wdata));
          else nt = 0;
          m_dat[a] <= int'(req_wdata);
          m_tag[a] <= nt;
        end
      end else if (m_pend && rsp_ready) begin
        m_pend <= 0;
      end
      if (evt) m_sticky <= 1;
      else if (cfg_we) m_sticky <= 0;
      if (cfg_we) m_cfg <= int'(cfg_wdata);
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n && cmp_on) begin
      chk(rsp_valid == m_pend, "R2 rsp_valid", rsp_valid, m_pend);
      chk(req_ready == !m_pend, "R2 req_ready", req_ready, !m_pend);
      if (m_pend) begin
        chk(int'(rsp_rdata) == m_rdata, "R3 rdata", rsp_rdata, m_rdata);
        chk(int'(rsp_tag) == m_rtag, "R3 tag", rsp_tag, m_rtag);
      end
      chk(irq == exp_irq(), "R7 irq", irq, exp_irq());
      chk(err == exp_err(), "R9 err", err, exp_err());
      chk(irq_sticky == m_sticky, "R8 sticky", irq_sticky, m_sticky);
    end
  end

  int l_data, l_tag, irq_cnt;
  bit l_irq, l_err;

  task automatic acc(input logic [1:0] k, input int a, input int d, input int stall);
    @(negedge clk);
    req_valid = 1'b1; req_kind = k; req_addr = AW'(a); req_wdata = DW'(d); rsp_ready = 1'b0;
    @(negedge clk);
    req_valid = 1'b0;
    l_data = int'(rsp_rdata); l_tag = int'(rsp_tag); l_irq = irq; l_err = err;
    if (irq) irq_cnt++;
    for (int i = 0; i < stall; i++) begin
      @(negedge clk);
      chk(rsp_valid && !req_ready, "R2 stall hold", rsp_valid, 1);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
  endtask

  task automatic cfg(input int v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = 8'(v);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(req_ready == 1 && rsp_valid == 0 && irq == 0 && err == 0 && irq_sticky == 0,
        "R1 reset outputs", {req_ready, rsp_valid, irq, err, irq_sticky}, 5'b10000);
    rst_n = 1'b1;
    @(negedge clk);
    cmp_on = 1'b1;
    chk(req_ready == 1 && irq_sticky == 0, "R1 after release", req_ready, 1);

    // debug entry: cleared register, rewrite all words (tags become 0)
    cfg(8'h00);
    for (int i = 0; i < DEPTH; i++) acc(2'd2, i, (i * 37 + 5) & 255, 0);
    acc(2'd1, 12, 0, 0);
    chk(l_data == ((12 * 37 + 5) & 255), "R3 readback", l_data, (12 * 37 + 5) & 255);
    chk(l_tag == 0, "R6 plain write tag", l_tag, 0);

    // set breakpoints by forcing the extra bit
    cfg(8'h03);
    acc(2'd2, 5, 8'h11, 0);
    acc(2'd2, 9, 8'h22, 0);
    cfg(8'h24); // trace + fetch mask
    acc(2'd0, 4, 0, 0);
    chk(l_irq == 0, "R7 untagged fetch", l_irq, 0);
    acc(2'd0, 5, 0, 0);
    chk(l_irq == 1 && l_tag == 1, "R4 R7 tagged fetch", l_irq, 1);
    chk(irq_sticky == 1, "R8 sticky set", irq_sticky, 1);
    acc(2'd1, 9, 0, 0);
    chk(l_irq == 0, "R7 read masked off", l_irq, 0);
    cfg(8'h44); // trace + read mask
    chk(irq_sticky == 0, "R8 sticky cleared", irq_sticky, 0);
    acc(2'd3, 9, 0, 0);
    chk(l_irq == 1, "R7 read kind 3", l_irq, 1);
    acc(2'd0, 9, 0, 0);
    chk(l_irq == 0, "R7 fetch masked off", l_irq, 0);
    cfg(8'h84); // trace + write mask
    acc(2'd2, 5, 8'h33, 3);
    chk(l_irq == 1 && l_data == 8'h11, "R7 write on old tag", l_irq, 1);
    cfg(8'hE4);
    acc(2'd0, 5, 0, 2);
    chk(l_irq == 0 && l_tag == 0, "R6 write cleared tag", l_tag, 0);
    acc(2'd1, 9, 0, 4);
    chk(l_irq == 1, "R7 all masks", l_irq, 1);

    // leave debug: parity generate, rewrite, then report errors
    cfg(8'h08);
    for (int i = 0; i < DEPTH; i++) acc(2'd2, i, (i * 53 + 3) & 255, 0);
    acc(2'd1, 1, 0, 0);
    chk(l_tag == par8(56), "R5 parity tag odd data", l_tag, par8(56));
    acc(2'd1, 2, 0, 0);
    chk(l_tag == par8(109), "R5 parity tag", l_tag, par8(109));
    cfg(8'h18);
    for (int i = 0; i < 8; i++) begin
      acc(2'd0, i, 0, 0);
      chk(l_err == 0, "R9 clean word", l_err, 0);
    end
    cfg(8'h03);
    acc(2'd2, 7, 8'h03, 0); // even data, tag forced to 1
    cfg(8'h18);
    acc(2'd1, 7, 0, 1);
    chk(l_err == 1, "R9 mismatch reported", l_err, 1);
    acc(2'd0, 7, 0, 0);
    chk(l_err == 1, "R9 mismatch on fetch", l_err, 1);
    cfg(8'h08);
    acc(2'd1, 7, 0, 0);
    chk(l_err == 0, "R9 report disabled", l_err, 0);
    cfg(8'h18);
    acc(2'd2, 7, 8'h03, 0);
    chk(l_err == 0, "R9 no error on write", l_err, 0);
    acc(2'd1, 7, 0, 0);
    chk(l_err == 0 && l_tag == 0, "R5 rewrite repairs", l_tag, 0);

    // single-step: tag a block and fetch it through
    cfg(8'h03);
    for (int i = 16; i < 32; i++) acc(2'd2, i, i, 0);
    cfg(8'h24);
    irq_cnt = 0;
    for (int i = 16; i < 32; i++) acc(2'd0, i, 0, i % 3);
    chk(irq_cnt == 16, "R10 one irq per fetch", irq_cnt, 16);

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule